// File: doc/BRIEF.md
# Self-Refresh Entry Sequencer with Handshake Timeout

This block takes over the DRAM command bus when memory has to be put into self-refresh, for example after the serial link has gone through a fast reset. On a request it first asks other on-chip logic, such as a built-in self-test engine, to release the bus. It does this with a handshake request and waits for an acknowledge. If no acknowledge arrives within a programmable, prescaled timeout, it takes the bus anyway and raises a sticky error flag. It then drives a per-rank entry sequence: a precharge-all followed by a self-refresh entry command. Rank 0 goes first, and rank 1 starts a programmable stagger later, so the current peaks of the two ranks do not coincide.

When no entry is in progress, the block also issues periodic auto-refresh commands to the two ranks, separated by a second programmable stagger. The three settings sit in one configuration word that software writes. The error flag is cleared by a write-one pulse.

The states are IDLE, HANDSHAKE, R0_PREA, R0_SRE, SR_GAP, R1_PREA, R1_SRE, FINISH, AR_R0, AR_GAP and AR_R1.

- IDLE moves to HANDSHAKE on a self-refresh request. Otherwise it moves to AR_R0 on an auto-refresh request.
- HANDSHAKE moves to R0_PREA on an acknowledge or on expiry.
- R0_PREA always moves to R0_SRE.
- R0_SRE moves to R1_PREA when the stagger is due, and to SR_GAP otherwise. SR_GAP moves to R1_PREA when the stagger is due.
- R1_PREA moves to R1_SRE, then to FINISH, then back to IDLE.
- AR_R0 moves to AR_R1 when the auto-refresh stagger is at most 1, and to AR_GAP otherwise. AR_GAP moves to AR_R1 when the stagger is due. AR_R1 returns to IDLE.

Top module: `sr_entry_seq`

## Requirements
- R1: After reset, cmd_valid, hs_req, seq_done and tmo_err are 0. The configuration resets to timeout count 0xFF and to a stagger of 0x14 for both self-refresh entry and auto-refresh.
- R2: A sre_req seen in IDLE raises hs_req from the next cycle on. hs_req stays high until the handshake ends, and no command is issued while it is high. sre_req takes priority over an ar_req in the same cycle; that ar_req is dropped. Requests seen outside IDLE are ignored.
- R3: An hs_ack seen while hs_req is high ends the handshake. The precharge-all to rank 0 follows in the next cycle, and hs_req is then 0.
- R4: With timeout count N and no acknowledge, the handshake lasts exactly 16*N+1 cycles. The entry sequence then starts anyway.
- R5: An expiry without an acknowledge sets tmo_err, which is visible in the cycle of the first precharge-all. An acknowledge in the expiry cycle itself takes precedence, and tmo_err is not set.
- R6: tmo_err stays set until an err_clr pulse. It reads 0 in the cycle after err_clr.
- R7: The entry sequence is as follows. The precharge-all to rank 0 (type 1, rank 0) is followed one cycle later by self-refresh entry to rank 0 (type 3, rank 0). The precharge-all to rank 1 comes max(G,2) cycles after the first precharge-all, where G is the entry stagger. Self-refresh entry to rank 1 comes one cycle after that. seq_done is a single-cycle pulse one cycle after the last command.
- R8: An ar_req seen in IDLE issues a refresh to rank 0 (type 2, rank 0) in the next cycle. It issues a refresh to rank 1 max(A,1) cycles later, where A is the auto-refresh stagger.
- R9: An hs_ack arriving after expiry has no effect on the commands. It is not remembered, so the next request still waits out its full timeout.
- R10: cfg_we loads cfg_wdata as follows: bits [7:0] are the entry stagger, bits [15:8] are the auto-refresh stagger, and bits [23:16] are the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 24 | Configuration word: entry stagger, refresh stagger, timeout |
| err_clr | input | 1 | Write-one clear of tmo_err |
| sre_req | input | 1 | Request self-refresh entry |
| ar_req | input | 1 | Request a staggered auto-refresh pair |
| hs_ack | input | 1 | Handshake acknowledge: bus released |
| hs_req | output | 1 | Handshake request to other bus owners |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_type | output | 2 | 1 precharge-all, 2 refresh, 3 self-refresh entry |
| cmd_rank | output | 1 | Target rank |
| seq_done | output | 1 | Pulse: both ranks are in self-refresh |
| tmo_err | output | 1 | Sticky handshake timeout error |

## Verification
The bench targets the edges of the prescaled timeout. With a count of 0 the block must leave the handshake after one cycle. An acknowledge landing exactly in the expiry cycle must win, so a design that let expiry win would raise a false error. An off-by-one prescaler would move every command by 16 cycles. Stagger values of 0, 1 and 2 are applied: a design that did not clamp them would overlap the rank 0 and rank 1 commands or issue them out of order. The bench also sends a late acknowledge, an auto-refresh request during the handshake, and a simultaneous pair of requests. A design that latched any of these would emit extra commands or cut the next timeout short.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PREA = 2'd1,
        CMD_REF  = 2'd2,
        CMD_SRE  = 2'd3
    } sr_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HANDSHAKE,
        ST_R0_PREA,
        ST_R0_SRE,
        ST_SR_GAP,
        ST_R1_PREA,
        ST_R1_SRE,
        ST_FINISH,
        ST_AR_R0,
        ST_AR_GAP,
        ST_AR_R1
    } sr_state_e;

endpackage

// File: rtl/sr_cfg_regs.sv
module sr_cfg_regs #(
    parameter int CNT_W       = 8,
    parameter int RST_TIMEOUT = 8'hFF,
    parameter int RST_AR_GAP  = 8'h14,
    parameter int RST_SR_GAP  = 8'h14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [3*CNT_W-1:0] wdata,
    output logic [CNT_W-1:0]   sr_gap,
    output logic [CNT_W-1:0]   ar_gap,
    output logic [CNT_W-1:0]   timeout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_gap  <= CNT_W'(RST_SR_GAP);
            ar_gap  <= CNT_W'(RST_AR_GAP);
            timeout <= CNT_W'(RST_TIMEOUT);
        end else if (we) begin
            sr_gap  <= wdata[CNT_W-1:0];
            ar_gap  <= wdata[2*CNT_W-1:CNT_W];
            timeout <= wdata[3*CNT_W-1:2*CNT_W];
        end
    end
endmodule

// File: rtl/sr_hs_timer.sv
module sr_hs_timer #(
    parameter int CNT_W    = 8,
    parameter int PRESCALE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0]  pre;
    logic [CNT_W-1:0] ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre   <= '0;
            ticks <= '0;
        end else if (!run) begin
            pre   <= '0;
            ticks <= '0;
        end else if (pre == PS_LAST) begin
            pre <= '0;
            if (ticks != '1) ticks <= ticks + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign expired = run && (ticks == limit);
endmodule

// File: rtl/sr_gap_timer.sv
module sr_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] gap,
    output logic             due
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   next_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CNT_W'(1);
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    assign next_pos = (CNT_W+1)'(cnt) + (CNT_W+1)'(1);
    assign due      = next_pos >= (CNT_W+1)'(gap);
endmodule

// File: rtl/sr_entry_seq.sv
module sr_entry_seq
    import sr_seq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PRESCALE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [3*CNT_W-1:0] cfg_wdata,
    input  logic               err_clr,
    input  logic               sre_req,
    input  logic               ar_req,
    input  logic               hs_ack,
    output logic               hs_req,
    output logic               cmd_valid,
    output logic [1:0]         cmd_type,
    output logic               cmd_rank,
    output logic               seq_done,
    output logic               tmo_err
);
    sr_state_e        state, nxt;
    sr_cmd_e          cmd_e;
    logic [CNT_W-1:0] sr_gap, ar_gap, timeout, gap_sel;
    logic             tmo_hit, gap_due, gap_start, in_ar;

    sr_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .sr_gap(sr_gap), .ar_gap(ar_gap), .timeout(timeout)
    );

    sr_hs_timer #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_hs (
        .clk(clk), .rst_n(rst_n), .run(state == ST_HANDSHAKE),
        .limit(timeout), .expired(tmo_hit)
    );

    assign in_ar     = (state == ST_AR_R0) || (state == ST_AR_GAP);
    assign gap_sel   = in_ar ? ar_gap : sr_gap;
    assign gap_start = (state == ST_R0_PREA) || (state == ST_AR_R0);

    sr_gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .start(gap_start),
        .gap(gap_sel), .due(gap_due)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sre_req)     nxt = ST_HANDSHAKE;
                else if (ar_req) nxt = ST_AR_R0;
            end
            ST_HANDSHAKE: if (hs_ack || tmo_hit) nxt = ST_R0_PREA;
            ST_R0_PREA:   nxt = ST_R0_SRE;
            ST_R0_SRE:    nxt = gap_due ? ST_R1_PREA : ST_SR_GAP;
            ST_SR_GAP:    if (gap_due) nxt = ST_R1_PREA;
            ST_R1_PREA:   nxt = ST_R1_SRE;
            ST_R1_SRE:    nxt = ST_FINISH;
            ST_FINISH:    nxt = ST_IDLE;
            ST_AR_R0:     nxt = (ar_gap <= CNT_W'(1)) ? ST_AR_R1 : ST_AR_GAP;
            ST_AR_GAP:    if (gap_due) nxt = ST_AR_R1;
            ST_AR_R1:     nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hs_req    = 1'b0;
        cmd_valid = 1'b0;
        cmd_e     = CMD_NONE;
        cmd_rank  = 1'b0;
        seq_done  = 1'b0;
        unique case (state)
            ST_HANDSHAKE: hs_req = 1'b1;
            ST_R0_PREA: begin cmd_valid = 1'b1; cmd_e = CMD_PREA; end
            ST_R0_SRE:  begin cmd_valid = 1'b1; cmd_e = CMD_SRE;  end
            ST_R1_PREA: begin cmd_valid = 1'b1; cmd_e = CMD_PREA; cmd_rank = 1'b1; end
            ST_R1_SRE:  begin cmd_valid = 1'b1; cmd_e = CMD_SRE;  cmd_rank = 1'b1; end
            ST_FINISH:  seq_done = 1'b1;
            ST_AR_R0:   begin cmd_valid = 1'b1; cmd_e = CMD_REF; end
            ST_AR_R1:   begin cmd_valid = 1'b1; cmd_e = CMD_REF; cmd_rank = 1'b1; end
            default: ;
        endcase
    end

    assign cmd_type = cmd_e;

    // sticky timeout flag: a new expiry wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmo_err <= 1'b0;
        else if (state == ST_HANDSHAKE && tmo_hit && !hs_ack)
            tmo_err <= 1'b1;
        else if (err_clr)
            tmo_err <= 1'b0;
    end
endmodule

// File: rtl/sr_entry_seq_chk.sv
module sr_entry_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_req,
    input logic       hs_ack,
    input logic       cmd_valid,
    input logic [1:0] cmd_type,
    input logic       cmd_rank,
    input logic       seq_done,
    input logic       tmo_err,
    input logic       err_clr
);
    a_r2_quiet_in_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req |-> !cmd_valid);

    a_r3_ack_starts_rank0: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req && hs_ack) |=> (cmd_valid && cmd_type == 2'd1 && !cmd_rank && !hs_req));

    a_r5_err_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> ($past(hs_req) && !$past(hs_ack)));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_err && !err_clr) |=> tmo_err);

    a_r7_done_after_rank1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd3 && cmd_rank) |=> seq_done);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    a_r7_valid_has_type: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_type != 2'd0));
endmodule

bind sr_entry_seq sr_entry_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .hs_ack(hs_ack),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_rank(cmd_rank),
    .seq_done(seq_done), .tmo_err(tmo_err), .err_clr(err_clr)
);

// File: tb/sim_sr_entry_seq.sv
module sim_sr_entry_seq;
    localparam int CLK_P = 10;
    localparam int K_PREA = 1, K_REF = 2, K_SRE = 3, K_DONE = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 1'b0, err_clr = 1'b0, sre_req = 1'b0, ar_req = 1'b0, hs_ack = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        hs_req, cmd_valid, cmd_rank, seq_done, tmo_err;
    logic [1:0]  cmd_type;

    int  cyc = 0;
    int  checks = 0, fails = 0;
    bit  err_model = 1'b0;
    bit  finished = 1'b0;

    typedef struct {
        int    kind;
        int    rank;
        int    at;
        string req;
    } exp_t;
    exp_t q[$];

    sr_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .err_clr(err_clr), .sre_req(sre_req), .ar_req(ar_req), .hs_ack(hs_ack),
        .hs_req(hs_req), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_rank(cmd_rank), .seq_done(seq_done), .tmo_err(tmo_err)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) tick();
    endtask

    task automatic push(input int kind, input int rank, input int at, input string req);
        exp_t e;
        e.kind = kind; e.rank = rank; e.at = at; e.req = req;
        q.push_back(e);
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // monitor: compare every produced item with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && (cmd_valid || seq_done)) begin
            int kind;
            kind = seq_done ? K_DONE : int'(cmd_type);
            if (q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R2/R7 unexpected item: actual kind %0d rank %0d expected none (cycle %0d)",
                         kind, cmd_rank, cyc);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, "kind", kind, e.kind);
                chk(e.req, "cycle", cyc, e.at);
                if (e.kind != K_DONE) chk(e.req, "rank", int'(cmd_rank), e.rank);
            end
        end
    end

    task automatic cfg_write(input int tmo, input int arg, input int srg);
        tick();
        cfg_we = 1'b1;
        cfg_wdata = {8'(tmo), 8'(arg), 8'(srg)};    // R10 field layout
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clear_err();
        tick();
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
        err_model = 1'b0;
        chk("R6", "tmo_err after clear", int'(tmo_err), 0);
    endtask

    // ack_d < 0: no acknowledge; otherwise ack in handshake cycle h+ack_d
    task automatic run_sre(input int ack_d, input int tmo, input int g,
                           input bit late_ack, input bit poke_ar, input bit also_ar,
                           input string req);
        int h, t0, t1;
        bit timed_out;
        tick();
        sre_req = 1'b1;
        ar_req  = also_ar;
        tick();
        sre_req = 1'b0;
        ar_req  = 1'b0;
        h = cyc;
        chk("R2", "hs_req in handshake", int'(hs_req), 1);
        timed_out = (ack_d < 0) || (ack_d > 16 * tmo);
        t0 = timed_out ? h + 16 * tmo + 1 : h + ack_d + 1;
        t1 = t0 + imax(g, 2);
        push(K_PREA, 0, t0, req);
        push(K_SRE,  0, t0 + 1, "R7");
        push(K_PREA, 1, t1, "R7");
        push(K_SRE,  1, t1 + 1, "R7");
        push(K_DONE, 0, t1 + 2, "R7");
        if (poke_ar && t0 > h + 1) begin
            ar_req = 1'b1;                          // R2: ignored outside IDLE
            tick();
            ar_req = 1'b0;
        end
        if (!timed_out) begin
            wait_until(h + ack_d);
            hs_ack = 1'b1;
            tick();
            hs_ack = 1'b0;
        end else begin
            wait_until(t0 - 1);
            chk("R5", "tmo_err before expiry", int'(tmo_err), int'(err_model));
            chk("R4", "hs_req held", int'(hs_req), 1);
            wait_until(t0);
            err_model = 1'b1;
        end
        chk("R5", "tmo_err at first command", int'(tmo_err), int'(err_model));
        chk("R3", "hs_req dropped", int'(hs_req), 0);
        if (late_ack) begin
            hs_ack = 1'b1;                          // R9: after expiry
            tick();
            hs_ack = 1'b0;
        end
        wait_until(t1 + 3);
    endtask

    task automatic run_ar(input int g, input string req);
        int c;
        tick();
        ar_req = 1'b1;
        c = cyc;
        push(K_REF, 0, c + 1, req);
        push(K_REF, 1, c + 1 + imax(g, 1), req);
        tick();
        ar_req = 1'b0;
        wait_until(c + 1 + imax(g, 1) + 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "cmd_valid in reset", int'(cmd_valid), 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "hs_req after reset", int'(hs_req), 0);
        chk("R1", "tmo_err after reset", int'(tmo_err), 0);
        chk("R1", "seq_done after reset", int'(seq_done), 0);

        // R1 defaults: entry stagger 20, refresh stagger 20, timeout 255
        run_sre(5, 255, 20, 1'b0, 1'b0, 1'b0, "R3");
        run_ar(20, "R8");
        run_sre(-1, 255, 20, 1'b0, 1'b0, 1'b0, "R4");

        // R6: sticky across idle cycles, then cleared
        repeat (5) tick();
        chk("R6", "tmo_err held", int'(tmo_err), 1);
        clear_err();

        // short timeout, zero stagger, late ack, refresh request while busy
        cfg_write(3, 0, 0);
        run_sre(-1, 3, 0, 1'b1, 1'b1, 1'b0, "R4");
        clear_err();
        // R9: late ack was not remembered, next request waits out again
        run_sre(-1, 3, 0, 1'b0, 1'b0, 1'b0, "R9");
        clear_err();
        // R5: acknowledge in the very expiry cycle wins
        run_sre(48, 3, 0, 1'b0, 1'b0, 1'b0, "R5");
        chk("R5", "no error when ack at expiry", int'(tmo_err), 0);

        // zero timeout and larger stagger
        cfg_write(0, 1, 7);
        run_sre(-1, 0, 7, 1'b0, 1'b0, 1'b0, "R4");
        clear_err();
        run_ar(1, "R8");
        run_ar(1, "R10");

        cfg_write(2, 5, 2);
        run_ar(5, "R8");
        run_sre(0, 2, 2, 1'b0, 1'b0, 1'b0, "R3");
        // R2: simultaneous requests, refresh dropped
        run_sre(10, 2, 2, 1'b0, 1'b0, 1'b1, "R2");
        cfg_write(2, 0, 1);
        run_ar(0, "R8");
        run_sre(1, 2, 1, 1'b0, 1'b0, 1'b0, "R7");

        repeat (5) tick();
        chk("R7", "scoreboard drained", q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule